// File: doc/BRIEF.md
# Dual-Clock Flagged FIFO with Reset-Latched Offset Port

This block is a first-in first-out buffer for words that cross from one clock domain to another. Words are written on a write clock and read on an unrelated read clock. Each side has two active-low enables, and a transfer on a side happens only when both of its enables are low. The storage is DATA_W bits wide, 9 by default, and DEPTH words deep. DEPTH is one of 64, 256, 512, 1024, 2048, 4096 or 8192. The write and read pointers cross between the domains as Gray code through synchronizer flops. The full and almost-full flags are produced in the write domain. The empty and almost-empty flags are produced in the read domain. All four flags are active low.

The second write enable has two possible roles, and the level it holds while reset is asserted picks one. If the pin is high during reset, it acts as a plain second write qualifier, and both threshold offsets keep their reset value. If the pin is low during reset, the block enters offset-load mode. In this mode the pin steers write cycles into two threshold registers, which are written in turn. It also steers read cycles so that those registers can be read back, in the same turn, on the data output. The data output is forced to zero unless the active-low output enable is asserted.

Top module: `dual_clk_flag_fifo`

## Requirements
- R1: While reset is low and after it is released with no traffic, empty_n is 0, full_n is 1, almost_empty_n is 0 and almost_full_n is 1.
- R2: Words come out in the order they were written. A write needs wr_en_a_n low and the qualifier condition of the current mode. A read needs rd_en_a_n and rd_en_b_n both low. If rd_en_b_n is high, or if wr_en_b_ld_n is high in qualifier mode, the transfer does not happen.
- R3: full_n goes low once DEPTH words are held. A write attempted while full_n is low is dropped, and the stored contents do not change.
- R4: A read attempted while empty_n is low leaves the read pointer unchanged, and rd_data keeps its previous value.
- R5: wr_en_b_ld_n is sampled on clock edges while rst_n is low. Low selects offset-load mode and high selects qualifier mode. The choice holds until the next reset.
- R6: In load mode, a write-clock edge with wr_en_a_n and wr_en_b_ld_n both low writes the low log2(DEPTH) bits of wr_data into an offset register and stores no data word. The registers are written in the cycle almost-empty offset, almost-full offset, almost-empty offset, and so on. Data writes in load mode need wr_en_b_ld_n high.
- R7: In load mode, a read-clock edge with rd_en_a_n and wr_en_b_ld_n both low puts the next offset register, zero-extended, on rd_data. The registers are read in the same cycle as R6, and the FIFO contents are not affected. Data reads in load mode need wr_en_b_ld_n high.
- R8: Both offsets reset to DEF_OFS, which is 7. In qualifier mode they never change.
- R9: almost_empty_n is 0 exactly when the number of stored words is at or below the almost-empty offset.
- R10: almost_full_n is 0 exactly when the number of free locations is at or below the almost-full offset.
- R11: While oe_n is high, rd_data is all zeros. While oe_n is low, rd_data shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset; must span edges of both clocks |
| wr_en_a_n | input | 1 | Primary write enable, active low |
| wr_en_b_ld_n | input | 1 | Second write enable or offset-load control, role latched at reset |
| wr_data | input | DATA_W | Write data, or offset value in load mode |
| rd_en_a_n | input | 1 | Primary read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | DATA_W | Read data or offset readback |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| almost_empty_n | output | 1 | Programmable almost-empty flag, active low |
| almost_full_n | output | 1 | Programmable almost-full flag, active low |

## Verification
The bench places occupancy exactly on each side of every threshold: the default offsets in qualifier mode, then loaded offsets in load mode. A design with an off-by-one compare, or one that sizes free space from the wrong end, would move a flag one word too early or too late. It pushes one word past full and reads once past empty, then checks that the dropped word never comes out and that the next real word is still in order. A pointer that moves on a blocked transfer would corrupt the sequence. In load mode it writes three offsets, with the third carrying high bits that must be discarded, and reads three back. A design that did not wrap the register order, did not truncate, or let readback disturb the data path would return the wrong values or would shift the flag thresholds.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    // Widest pointer supported: 8192 words need 13 address bits plus a wrap bit.
    localparam int unsigned GRAY_MAX_W = 14;

    // Which threshold register the load/readback sequencer points at next.
    typedef enum logic {
        OFS_LOW  = 1'b0,   // almost-empty threshold
        OFS_HIGH = 1'b1    // almost-full threshold
    } ofs_sel_e;

    function automatic logic [GRAY_MAX_W-1:0] bin_to_gray(input logic [GRAY_MAX_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GRAY_MAX_W-1:0] gray_to_bin(input logic [GRAY_MAX_W-1:0] g);
        logic [GRAY_MAX_W-1:0] b;
        b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
        for (int i = GRAY_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
    parameter int unsigned W      = 7,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] gray_out
);

    logic [STAGES-1:0][W-1:0] pipe_d;
    logic [STAGES-1:0][W-1:0] pipe_q;

    assign pipe_d[0] = gray_in;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        assign pipe_d[s] = pipe_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign gray_out = pipe_q[STAGES-1];

endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int unsigned DATA_W = 9,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];

endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int unsigned DATA_W  = 9,
    parameter int unsigned DEPTH   = 64,
    parameter int unsigned DEF_OFS = 7,
    localparam int unsigned ADDR_W = $clog2(DEPTH),
    localparam int unsigned PTR_W  = ADDR_W + 1,
    localparam int unsigned OFS_W  = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_a_n,
    input  logic              en_b_ld_n,
    input  logic [DATA_W-1:0] din,
    input  logic [PTR_W-1:0]  rgray_sync,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [PTR_W-1:0]  wbin,
    output logic [PTR_W-1:0]  wgray,
    output logic              full,
    output logic              afull,
    output logic [OFS_W-1:0]  ae_ofs,
    output logic [OFS_W-1:0]  af_ofs,
    output logic              ld_mode
);

    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        logic             full;
        logic             afull;
        logic [OFS_W-1:0] ae_ofs;
        logic [OFS_W-1:0] af_ofs;
        ofs_sel_e         sel;
    } wr_st_t;

    localparam wr_st_t WR_RST = '{
        bin:    '0,
        gray:   '0,
        full:   1'b0,
        afull:  1'b0,
        ae_ofs: OFS_W'(DEF_OFS),
        af_ofs: OFS_W'(DEF_OFS),
        sel:    OFS_LOW
    };

    wr_st_t st_d, st_q;
    logic   mode_d, mode_q;

    logic             load_hit;
    logic             push_req;
    logic             push;
    logic [PTR_W-1:0] rbin_sync;
    logic [PTR_W-1:0] full_match;
    logic [PTR_W-1:0] used;
    logic [PTR_W-1:0] free_cnt;
    logic [OFS_W-1:0] ofs_in;

    // Role of the shared pin is captured on every edge while reset is held.
    always_comb begin
        mode_d = rst_n ? mode_q : ~en_b_ld_n;
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    always_comb begin
        st_d       = st_q;
        ofs_in     = OFS_W'(din);
        load_hit   = mode_q & ~en_a_n & ~en_b_ld_n;
        push_req   = ~en_a_n & (mode_q ? en_b_ld_n : ~en_b_ld_n);
        push       = push_req & ~st_q.full;

        if (push) begin
            st_d.bin = st_q.bin + 1'b1;
        end
        st_d.gray = PTR_W'(bin_to_gray(GRAY_MAX_W'(st_d.bin)));

        if (load_hit) begin
            if (st_q.sel == OFS_LOW) begin
                st_d.ae_ofs = ofs_in;
                st_d.sel    = OFS_HIGH;
            end else begin
                st_d.af_ofs = ofs_in;
                st_d.sel    = OFS_LOW;
            end
        end

        // Flags are evaluated on the post-edge pointer so they register without lag.
        rbin_sync  = PTR_W'(gray_to_bin(GRAY_MAX_W'(rgray_sync)));
        full_match = {~rgray_sync[PTR_W-1:PTR_W-2], rgray_sync[PTR_W-3:0]};
        st_d.full  = (st_d.gray == full_match);
        used       = st_d.bin - rbin_sync;
        free_cnt   = DEPTH_P - used;
        st_d.afull = (free_cnt <= PTR_W'(st_d.af_ofs));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= WR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we    = push;
    assign mem_waddr = st_q.bin[ADDR_W-1:0];
    assign wbin      = st_q.bin;
    assign wgray     = st_q.gray;
    assign full      = st_q.full;
    assign afull     = st_q.afull;
    assign ae_ofs    = st_q.ae_ofs;
    assign af_ofs    = st_q.af_ofs;
    assign ld_mode   = mode_q;

endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int unsigned DATA_W  = 9,
    parameter int unsigned DEPTH   = 64,
    localparam int unsigned ADDR_W = $clog2(DEPTH),
    localparam int unsigned PTR_W  = ADDR_W + 1,
    localparam int unsigned OFS_W  = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_a_n,
    input  logic              en_b_n,
    input  logic              ld_n,
    input  logic [OFS_W-1:0]  ae_ofs,
    input  logic [OFS_W-1:0]  af_ofs,
    input  logic [PTR_W-1:0]  wgray_sync,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [PTR_W-1:0]  rbin,
    output logic [PTR_W-1:0]  rgray,
    output logic              empty,
    output logic              aempty,
    output logic [DATA_W-1:0] dout
);

    typedef struct packed {
        logic [PTR_W-1:0]  bin;
        logic [PTR_W-1:0]  gray;
        logic              empty;
        logic              aempty;
        logic [DATA_W-1:0] dout;
        ofs_sel_e          sel;
    } rd_st_t;

    localparam rd_st_t RD_RST = '{
        bin:    '0,
        gray:   '0,
        empty:  1'b1,
        aempty: 1'b1,
        dout:   '0,
        sel:    OFS_LOW
    };

    rd_st_t st_d, st_q;
    logic   mode_d, mode_q;

    logic             rb_hit;
    logic             pop_req;
    logic             pop;
    logic [PTR_W-1:0] wbin_sync;
    logic [PTR_W-1:0] occ;

    // Each domain latches the pin role on its own clock during reset.
    always_comb begin
        mode_d = rst_n ? mode_q : ~ld_n;
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    always_comb begin
        st_d    = st_q;
        rb_hit  = mode_q & ~en_a_n & ~ld_n;
        pop_req = ~en_a_n & ~en_b_n & ~(mode_q & ~ld_n);
        pop     = pop_req & ~st_q.empty;

        if (pop) begin
            st_d.bin  = st_q.bin + 1'b1;
            st_d.dout = mem_rdata;
        end else if (rb_hit) begin
            if (st_q.sel == OFS_LOW) begin
                st_d.dout = DATA_W'(ae_ofs);
                st_d.sel  = OFS_HIGH;
            end else begin
                st_d.dout = DATA_W'(af_ofs);
                st_d.sel  = OFS_LOW;
            end
        end
        st_d.gray = PTR_W'(bin_to_gray(GRAY_MAX_W'(st_d.bin)));

        wbin_sync   = PTR_W'(gray_to_bin(GRAY_MAX_W'(wgray_sync)));
        st_d.empty  = (st_d.gray == wgray_sync);
        occ         = wbin_sync - st_d.bin;
        st_d.aempty = (occ <= PTR_W'(ae_ofs));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RD_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_raddr = st_q.bin[ADDR_W-1:0];
    assign rbin      = st_q.bin;
    assign rgray     = st_q.gray;
    assign empty     = st_q.empty;
    assign aempty    = st_q.aempty;
    assign dout      = st_q.dout;

endmodule

// File: rtl/dual_clk_flag_fifo.sv
module dual_clk_flag_fifo #(
    parameter int unsigned DATA_W      = 9,
    parameter int unsigned DEPTH       = 64,
    parameter int unsigned DEF_OFS     = 7,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned ADDR_W     = $clog2(DEPTH),
    localparam int unsigned PTR_W      = ADDR_W + 1,
    localparam int unsigned OFS_W      = ADDR_W
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en_a_n,
    input  logic              wr_en_b_ld_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_a_n,
    input  logic              rd_en_b_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              full_n,
    output logic              almost_empty_n,
    output logic              almost_full_n
);

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [PTR_W-1:0]  w_bin, w_gray, w_gray_sync;
    logic [PTR_W-1:0]  r_bin, r_gray, r_gray_sync;
    logic [OFS_W-1:0]  ae_ofs, af_ofs;
    logic              w_full, w_afull, w_ld_mode;
    logic              r_empty, r_aempty;
    logic [DATA_W-1:0] r_dout;

    dcf_wr_ctrl #(
        .DATA_W  (DATA_W),
        .DEPTH   (DEPTH),
        .DEF_OFS (DEF_OFS)
    ) u_wr (
        .clk        (wr_clk),
        .rst_n      (rst_n),
        .en_a_n     (wr_en_a_n),
        .en_b_ld_n  (wr_en_b_ld_n),
        .din        (wr_data),
        .rgray_sync (r_gray_sync),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .wbin       (w_bin),
        .wgray      (w_gray),
        .full       (w_full),
        .afull      (w_afull),
        .ae_ofs     (ae_ofs),
        .af_ofs     (af_ofs),
        .ld_mode    (w_ld_mode)
    );

    dcf_rd_ctrl #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_rd (
        .clk        (rd_clk),
        .rst_n      (rst_n),
        .en_a_n     (rd_en_a_n),
        .en_b_n     (rd_en_b_n),
        .ld_n       (wr_en_b_ld_n),
        .ae_ofs     (ae_ofs),
        .af_ofs     (af_ofs),
        .wgray_sync (w_gray_sync),
        .mem_rdata  (mem_rdata),
        .mem_raddr  (mem_raddr),
        .rbin       (r_bin),
        .rgray      (r_gray),
        .empty      (r_empty),
        .aempty     (r_aempty),
        .dout       (r_dout)
    );

    dcf_gray_sync #(
        .W      (PTR_W),
        .STAGES (SYNC_STAGES)
    ) u_w2r (
        .clk      (rd_clk),
        .rst_n    (rst_n),
        .gray_in  (w_gray),
        .gray_out (w_gray_sync)
    );

    dcf_gray_sync #(
        .W      (PTR_W),
        .STAGES (SYNC_STAGES)
    ) u_r2w (
        .clk      (wr_clk),
        .rst_n    (rst_n),
        .gray_in  (r_gray),
        .gray_out (r_gray_sync)
    );

    dcf_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_mem (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (wr_data),
        .raddr  (mem_raddr),
        .rdata  (mem_rdata)
    );

    assign rd_data        = oe_n ? '0 : r_dout;
    assign empty_n        = ~r_empty;
    assign full_n         = ~w_full;
    assign almost_empty_n = ~r_aempty;
    assign almost_full_n  = ~w_afull;

endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int unsigned PTR_W = 7,
    parameter int unsigned OFS_W = 6
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst_n,
    input logic             full_n,
    input logic             empty_n,
    input logic             almost_full_n,
    input logic             almost_empty_n,
    input logic [PTR_W-1:0] wbin,
    input logic [PTR_W-1:0] rbin,
    input logic [PTR_W-1:0] wgray,
    input logic [PTR_W-1:0] rgray,
    input logic             ld_mode,
    input logic [OFS_W-1:0] ae_ofs,
    input logic [OFS_W-1:0] af_ofs
);

    assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |=> $stable(wbin));

    assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |=> $stable(rbin));

    assert_full_is_almost_full_R10: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !almost_full_n);

    assert_empty_is_almost_empty_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !almost_empty_n);

    assert_fixed_offsets_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !ld_mode |-> ($stable(ae_ofs) && $stable(af_ofs)));

    assert_wgray_step_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    assert_rgray_step_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

endmodule

bind dual_clk_flag_fifo dcf_checker #(
    .PTR_W (PTR_W),
    .OFS_W (OFS_W)
) u_chk (
    .wr_clk         (wr_clk),
    .rd_clk         (rd_clk),
    .rst_n          (rst_n),
    .full_n         (full_n),
    .empty_n        (empty_n),
    .almost_full_n  (almost_full_n),
    .almost_empty_n (almost_empty_n),
    .wbin           (w_bin),
    .rbin           (r_bin),
    .wgray          (w_gray),
    .rgray          (r_gray),
    .ld_mode        (w_ld_mode),
    .ae_ofs         (ae_ofs),
    .af_ofs         (af_ofs)
);

// File: tb/sim_dual_clk_flag_fifo.sv
`timescale 1ns/1ps
module sim_dual_clk_flag_fifo;

    localparam int DW    = 9;
    localparam int DEPTH = 64;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst_n  = 1'b0;
    logic          wr_en_a_n = 1'b1;
    logic          wr_en_b_ld_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_a_n = 1'b1;
    logic          rd_en_b_n = 1'b0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] rd_data;
    logic          empty_n, full_n, almost_empty_n, almost_full_n;

    int            n_chk  = 0;
    int            n_fail = 0;
    int            model_cnt = 0;
    logic          exp_pop = 1'b0;
    logic [DW-1:0] sb_q[$];
    logic [DW-1:0] mon_exp;
    logic [DW-1:0] last_out;

    always #4 wr_clk = ~wr_clk;   // 125 MHz
    always #5 rd_clk = ~rd_clk;

    dual_clk_flag_fifo u0 (
        .wr_clk         (wr_clk),
        .rd_clk         (rd_clk),
        .rst_n          (rst_n),
        .wr_en_a_n      (wr_en_a_n),
        .wr_en_b_ld_n   (wr_en_b_ld_n),
        .wr_data        (wr_data),
        .rd_en_a_n      (rd_en_a_n),
        .rd_en_b_n      (rd_en_b_n),
        .oe_n           (oe_n),
        .rd_data        (rd_data),
        .empty_n        (empty_n),
        .full_n         (full_n),
        .almost_empty_n (almost_empty_n),
        .almost_full_n  (almost_full_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // pin_level: value held on the shared pin during reset; idle_level afterwards.
    task automatic do_reset(input logic pin_level, input logic idle_level);
        @(negedge wr_clk);
        rst_n = 1'b0;
        wr_en_b_ld_n = pin_level;
        wr_en_a_n = 1'b1;
        rd_en_a_n = 1'b1;
        sb_q.delete();
        model_cnt = 0;
        repeat (4) @(posedge wr_clk);
        repeat (4) @(posedge rd_clk);
        @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (3) @(posedge rd_clk);
        repeat (3) @(posedge wr_clk);
        @(negedge wr_clk);
        wr_en_b_ld_n = idle_level;
    endtask

    task automatic settle();
        repeat (6) @(posedge wr_clk);
        repeat (6) @(posedge rd_clk);
        @(negedge rd_clk);
    endtask

    // Driver: one write cycle; expected item queued when the model has room.
    task automatic push(input logic [DW-1:0] v);
        @(negedge wr_clk);
        wr_data = v;
        wr_en_a_n = 1'b0;
        @(negedge wr_clk);
        wr_en_a_n = 1'b1;
        if (model_cnt < DEPTH) begin
            sb_q.push_back(v);
            model_cnt++;
        end
    endtask

    task automatic push_n(input int count, input logic [DW-1:0] base);
        for (int i = 0; i < count; i++) begin
            push(base + DW'(i));
        end
    endtask

    // A write cycle the model treats as blocked.
    task automatic push_blocked(input logic [DW-1:0] v);
        @(negedge wr_clk);
        wr_data = v;
        wr_en_a_n = 1'b0;
        @(negedge wr_clk);
        wr_en_a_n = 1'b1;
    endtask

    task automatic pop_one();
        @(negedge rd_clk);
        rd_en_a_n = 1'b0;
        exp_pop = (model_cnt > 0);
        if (model_cnt > 0) model_cnt--;
        @(negedge rd_clk);
        rd_en_a_n = 1'b1;
        exp_pop = 1'b0;
    endtask

    task automatic pop_n(input int count);
        for (int i = 0; i < count; i++) begin
            pop_one();
        end
    endtask

    task automatic read_blocked();
        @(negedge rd_clk);
        rd_en_a_n = 1'b0;
        @(negedge rd_clk);
        rd_en_a_n = 1'b1;
    endtask

    task automatic load_ofs(input logic [DW-1:0] v);
        @(negedge wr_clk);
        wr_data = v;
        wr_en_a_n = 1'b0;
        wr_en_b_ld_n = 1'b0;
        @(negedge wr_clk);
        wr_en_a_n = 1'b1;
        wr_en_b_ld_n = 1'b1;
    endtask

    task automatic readback(input logic [DW-1:0] exp, input string tag);
        @(negedge rd_clk);
        rd_en_a_n = 1'b0;
        wr_en_b_ld_n = 1'b0;
        @(negedge rd_clk);
        rd_en_a_n = 1'b1;
        wr_en_b_ld_n = 1'b1;
        check(tag, 32'(rd_data), 32'(exp));
    endtask

    // Monitor: compares each data read against the scoreboard head.
    always @(posedge rd_clk) begin
        if (exp_pop) begin
            #1;
            if (sb_q.size() == 0) begin
                check("R2 scoreboard underrun", 32'd1, 32'd0);
            end else begin
                mon_exp = sb_q.pop_front();
                check("R2 read order", 32'(rd_data), 32'(mon_exp));
            end
        end
    end

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // ---------------- qualifier mode: pin high during reset ----------------
        do_reset(1'b1, 1'b0);
        check("R1 empty_n after reset", 32'(empty_n), 32'd0);
        check("R1 full_n after reset", 32'(full_n), 32'd1);
        check("R1 almost_empty_n after reset", 32'(almost_empty_n), 32'd0);
        check("R1 almost_full_n after reset", 32'(almost_full_n), 32'd1);

        // basic transfer
        push(9'h0A1); push(9'h152); push(9'h0C3);
        settle();
        check("R2 empty_n with data", 32'(empty_n), 32'd1);
        pop_n(3);
        settle();
        check("R2 empty_n drained", 32'(empty_n), 32'd0);
        last_out = rd_data;
        check("R2 last word", 32'(last_out), 32'h0C3);

        // output enable
        oe_n = 1'b1; #1;
        check("R11 rd_data gated", 32'(rd_data), 32'd0);
        oe_n = 1'b0; #1;
        check("R11 rd_data restored", 32'(rd_data), 32'(last_out));

        // second write enable high blocks the write
        wr_en_b_ld_n = 1'b1;
        push_blocked(9'h0F0);
        wr_en_b_ld_n = 1'b0;
        settle();
        check("R2 write blocked by second enable", 32'(empty_n), 32'd0);

        // second read enable high blocks the read
        push(9'h111);
        settle();
        rd_en_b_n = 1'b1;
        read_blocked();
        settle();
        check("R2 read blocked: data held", 32'(rd_data), 32'(last_out));
        check("R2 read blocked: still non-empty", 32'(empty_n), 32'd1);
        rd_en_b_n = 1'b0;
        pop_one();
        settle();

        // thresholds with default offsets (7)
        push_n(7, 9'h020);
        settle();
        check("R8 R9 almost-empty at 7 words", 32'(almost_empty_n), 32'd0);
        push(9'h027);
        settle();
        check("R8 R9 almost-empty clear at 8 words", 32'(almost_empty_n), 32'd1);
        push_n(48, 9'h028);
        settle();
        check("R8 R10 almost-full clear at 56 words", 32'(almost_full_n), 32'd1);
        push(9'h058);
        settle();
        check("R8 R10 almost-full at 57 words", 32'(almost_full_n), 32'd0);
        push_n(7, 9'h059);
        settle();
        check("R3 full at DEPTH", 32'(full_n), 32'd0);
        push(9'h1AA);  // dropped, model has no room
        settle();
        check("R3 still full after extra write", 32'(full_n), 32'd0);
        pop_n(DEPTH);
        settle();
        check("R3 full cleared after drain", 32'(full_n), 32'd1);
        check("R4 empty after drain", 32'(empty_n), 32'd0);
        check("R3 no extra word left", 32'(sb_q.size()), 32'd0);

        // read while empty
        last_out = rd_data;
        read_blocked();
        settle();
        check("R4 data held on empty read", 32'(rd_data), 32'(last_out));
        check("R4 empty unchanged", 32'(empty_n), 32'd0);
        push(9'h055);
        settle();
        pop_one();
        settle();

        // ---------------- load mode: pin low during reset ----------------
        do_reset(1'b0, 1'b1);
        check("R1 R5 empty_n after load-mode reset", 32'(empty_n), 32'd0);
        load_ofs(9'h003);
        load_ofs(9'h00A);
        load_ofs(9'h1C5);   // wraps to almost-empty offset; high bits dropped -> 5
        settle();
        check("R6 load cycles store no data", 32'(empty_n), 32'd0);
        readback(9'h005, "R5 R6 R7 readback almost-empty offset");
        readback(9'h00A, "R6 R7 readback almost-full offset");
        readback(9'h005, "R7 readback wraps");
        settle();
        check("R7 readback leaves FIFO empty", 32'(empty_n), 32'd0);

        push_n(5, 9'h100);
        settle();
        check("R6 R9 almost-empty at loaded 5", 32'(almost_empty_n), 32'd0);
        push(9'h105);
        settle();
        check("R6 R9 almost-empty clear at 6", 32'(almost_empty_n), 32'd1);
        push_n(47, 9'h106);
        settle();
        check("R6 R10 almost-full clear at 53 words", 32'(almost_full_n), 32'd1);
        push(9'h135);
        settle();
        check("R6 R10 almost-full at 54 words", 32'(almost_full_n), 32'd0);
        pop_n(54);
        settle();
        check("R6 empty after load-mode drain", 32'(empty_n), 32'd0);
        check("R6 all words returned", 32'(sb_q.size()), 32'd0);

        finish_run();
    end

endmodule